// File: doc/BRIEF.md
# Register File with Shadow Operand Bank

This block is the integer register file of a small in-order core that also issues custom multi-input instructions to attached programmable logic. Alongside the ordinary core registers, read through two base ports and written through one port, it keeps a small bank of shadow registers. A shadow register is filled only when the writing instruction asks for it, and it is visible only to the custom-instruction operand path. As a result, a custom operation with three or four inputs can get its extra operands without spending move cycles on the two-port core file.

Every write carries three control fields: a forward flag, a subword select and a shadow index. When the forward flag is set, the written value, trimmed by the subword select, is also stored in the indexed shadow register on the same clock edge as the core writeback. The gather port presents up to four operands. Each slot takes its value from either a core register or a shadow register. Any core-sourced operand beyond the two that the read ports can supply is flagged as needing an extra move cycle, so the pipeline can stall.

Top module: `shadow_regfile`

## Requirements
- R1: Reset sets every core register and every shadow register to zero.
- R2: Core register 0 always reads as zero, and a write addressed to it leaves it zero.
- R3: The base ports `rd_a` and `rd_b` return the stored core value. A write with `wr_en` high becomes visible on the clock edge that follows, and a read of the same address in the write cycle returns the old value.
- R4: When `wr_en` and `wr_fwd` are both high, the shadow register chosen by `wr_shid` takes the written value on the same edge as the core write. When `wr_fwd` is low, every shadow register keeps its value.
- R5: `wr_sub` selects what is stored in the shadow register. Code 0 or 3 stores the full word. Code 1 stores the low half in the low bits, with the upper half zero. Code 2 stores the high half moved into the low bits, with the upper half zero.
- R6: A forwarded write to core address 0 still updates the shadow register, and the base ports have no path to the shadow bank.
- R7: A used gather slot with `cx_from_sh` low presents the core register named by its `cx_core_idx` field. With `cx_from_sh` high, it presents the shadow register named by its `cx_sh_id` field. Slot i occupies bits [i*W +: W] of each packed gather bus.
- R8: A gather read of a shadow register that is being written in the same cycle returns the new value.
- R9: A shadow index of NSHADOW or above is ignored on write and reads as zero.
- R10: Used, core-sourced slots are counted in slot order from slot 0. The third and later ones raise their bit in `cx_move_req`, and `cx_stall` is high exactly when any bit of `cx_move_req` is set.
- R11: A slot with its `cx_use` bit low presents zero and never raises a move request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_addr | input | AW | Base read port A address |
| rd_a_data | output | XLEN | Base read port A data |
| rd_b_addr | input | AW | Base read port B address |
| rd_b_data | output | XLEN | Base read port B data |
| wr_en | input | 1 | Core write enable |
| wr_addr | input | AW | Core write address |
| wr_data | input | XLEN | Write value |
| wr_fwd | input | 1 | Also copy the value into a shadow register |
| wr_sub | input | 2 | Subword select (0/3 full, 1 low half, 2 high half) |
| wr_shid | input | SHID_W | Target shadow register |
| cx_use | input | NOPS | Per-slot operand used |
| cx_from_sh | input | NOPS | Per-slot source is the shadow bank |
| cx_core_idx | input | NOPS*AW | Per-slot core register index |
| cx_sh_id | input | NOPS*SHID_W | Per-slot shadow register index |
| cx_opnd | output | NOPS*XLEN | Gathered operands |
| cx_move_req | output | NOPS | Per-slot extra move cycle needed |
| cx_stall | output | 1 | Any move cycle needed |

## Verification
A table of forwarded and plain writes sweeps every subword code and several shadow targets, including a write to core address 0. Each entry reads back both banks, which separates correct trimming from a wrong half or missing zero fill, and a held shadow from a clobbered one. Gather patterns mix core and shadow sources, all-core, all-shadow and a hole in the slot mask. These tell apart correct move counting in slot order from counting shadow or unused slots. Same-cycle read-during-write cases separate the shadow bypass from the unbypassed core path, and an out-of-range index shows whether a write can alias onto a real shadow register.

// File: rtl/srf_pkg.sv
package srf_pkg;
    typedef enum logic [1:0] {
        SUB_FULL  = 2'd0,
        SUB_LOW   = 2'd1,
        SUB_HIGH  = 2'd2,
        SUB_FULL2 = 2'd3
    } subsel_e;
endpackage

// File: rtl/srf_core_bank.sv
module srf_core_bank #(
    parameter int XLEN   = 32,
    parameter int NREGS  = 16,
    parameter int NRP    = 6,
    localparam int AW    = $clog2(NREGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [AW-1:0]       waddr,
    input  logic [XLEN-1:0]     wdata,
    input  logic [NRP*AW-1:0]   raddr,
    output logic [NRP*XLEN-1:0] rdata
);
    logic [XLEN-1:0] regs_d [NREGS];
    logic [XLEN-1:0] regs_q [NREGS];

    always_comb begin
        for (int k = 0; k < NREGS; k++) begin
            regs_d[k] = regs_q[k];
        end
        if (we && (waddr != '0)) begin
            regs_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < NREGS; k++) begin
            if (!rst_n) regs_q[k] <= '0;
            else        regs_q[k] <= regs_d[k];
        end
    end

    for (genvar p = 0; p < NRP; p++) begin : g_rport
        logic [AW-1:0] a;
        assign a = raddr[p*AW +: AW];
        assign rdata[p*XLEN +: XLEN] = (a == '0) ? '0 : regs_q[a];
    end
endmodule

// File: rtl/srf_shadow_bank.sv
module srf_shadow_bank
    import srf_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int NSHADOW = 4,
    parameter int SHID_W  = 3,
    parameter int NRD     = 4,
    localparam int HALF   = XLEN / 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [1:0]              wsub,
    input  logic [SHID_W-1:0]       wid,
    input  logic [XLEN-1:0]         wdata,
    input  logic [NRD*SHID_W-1:0]   rid,
    output logic [NRD*XLEN-1:0]     rdata,
    output logic [NSHADOW*XLEN-1:0] state
);
    logic [XLEN-1:0] sh_d [NSHADOW];
    logic [XLEN-1:0] sh_q [NSHADOW];
    logic [XLEN-1:0] trim;

    always_comb begin
        case (wsub)
            SUB_LOW:  trim = {{(XLEN-HALF){1'b0}}, wdata[HALF-1:0]};
            SUB_HIGH: trim = {{HALF{1'b0}}, wdata[XLEN-1:HALF]};
            default:  trim = wdata;
        endcase
        for (int k = 0; k < NSHADOW; k++) begin
            sh_d[k] = sh_q[k];
            if (we && (wid == SHID_W'(k))) begin
                sh_d[k] = trim;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < NSHADOW; k++) begin
            if (!rst_n) sh_q[k] <= '0;
            else        sh_q[k] <= sh_d[k];
        end
    end

    // Reads use the next-state value, which gives write-through for free;
    // an index with no matching register falls through to zero.
    always_comb begin
        for (int r = 0; r < NRD; r++) begin
            rdata[r*XLEN +: XLEN] = '0;
            for (int k = 0; k < NSHADOW; k++) begin
                if (rid[r*SHID_W +: SHID_W] == SHID_W'(k)) begin
                    rdata[r*XLEN +: XLEN] = sh_d[k];
                end
            end
        end
    end

    for (genvar k = 0; k < NSHADOW; k++) begin : g_state
        assign state[k*XLEN +: XLEN] = sh_q[k];
    end
endmodule

// File: rtl/srf_gather.sv
module srf_gather #(
    parameter int XLEN   = 32,
    parameter int NOPS   = 4,
    parameter int NPORTS = 2
) (
    input  logic [NOPS-1:0]      use_i,
    input  logic [NOPS-1:0]      from_sh,
    input  logic [NOPS*XLEN-1:0] core_val,
    input  logic [NOPS*XLEN-1:0] sh_val,
    output logic [NOPS*XLEN-1:0] opnd,
    output logic [NOPS-1:0]      move_req,
    output logic                 stall
);
    always_comb begin
        int ncore;
        ncore = 0;
        for (int i = 0; i < NOPS; i++) begin
            opnd[i*XLEN +: XLEN] = '0;
            move_req[i]          = 1'b0;
            if (use_i[i]) begin
                if (from_sh[i]) begin
                    opnd[i*XLEN +: XLEN] = sh_val[i*XLEN +: XLEN];
                end else begin
                    opnd[i*XLEN +: XLEN] = core_val[i*XLEN +: XLEN];
                    if (ncore >= NPORTS) move_req[i] = 1'b1;
                    ncore = ncore + 1;
                end
            end
        end
        stall = |move_req;
    end
endmodule

// File: rtl/shadow_regfile.sv
module shadow_regfile #(
    parameter int XLEN    = 32,
    parameter int NREGS   = 16,
    parameter int NSHADOW = 4,
    parameter int SHID_W  = 3,
    parameter int NOPS    = 4,
    localparam int NPORTS = 2,
    localparam int AW     = $clog2(NREGS),
    localparam int NRP    = NPORTS + NOPS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [AW-1:0]          rd_a_addr,
    output logic [XLEN-1:0]        rd_a_data,
    input  logic [AW-1:0]          rd_b_addr,
    output logic [XLEN-1:0]        rd_b_data,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [XLEN-1:0]        wr_data,
    input  logic                   wr_fwd,
    input  logic [1:0]             wr_sub,
    input  logic [SHID_W-1:0]      wr_shid,
    input  logic [NOPS-1:0]        cx_use,
    input  logic [NOPS-1:0]        cx_from_sh,
    input  logic [NOPS*AW-1:0]     cx_core_idx,
    input  logic [NOPS*SHID_W-1:0] cx_sh_id,
    output logic [NOPS*XLEN-1:0]   cx_opnd,
    output logic [NOPS-1:0]        cx_move_req,
    output logic                   cx_stall
);
    logic [NRP*XLEN-1:0]     core_rd;
    logic [NOPS*XLEN-1:0]    sh_rd;
    logic [NSHADOW*XLEN-1:0] sh_state;

    srf_core_bank #(.XLEN(XLEN), .NREGS(NREGS), .NRP(NRP)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr ({cx_core_idx, rd_b_addr, rd_a_addr}),
        .rdata (core_rd)
    );

    srf_shadow_bank #(.XLEN(XLEN), .NSHADOW(NSHADOW), .SHID_W(SHID_W), .NRD(NOPS)) u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en && wr_fwd),
        .wsub  (wr_sub),
        .wid   (wr_shid),
        .wdata (wr_data),
        .rid   (cx_sh_id),
        .rdata (sh_rd),
        .state (sh_state)
    );

    assign rd_a_data = core_rd[0 +: XLEN];
    assign rd_b_data = core_rd[XLEN +: XLEN];

    srf_gather #(.XLEN(XLEN), .NOPS(NOPS), .NPORTS(NPORTS)) u_gather (
        .use_i    (cx_use),
        .from_sh  (cx_from_sh),
        .core_val (core_rd[NPORTS*XLEN +: NOPS*XLEN]),
        .sh_val   (sh_rd),
        .opnd     (cx_opnd),
        .move_req (cx_move_req),
        .stall    (cx_stall)
    );
endmodule

// File: rtl/srf_checker.sv
module srf_checker #(
    parameter int XLEN    = 32,
    parameter int NSHADOW = 4,
    parameter int SHID_W  = 3,
    parameter int NOPS    = 4,
    parameter int AW      = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [AW-1:0]           rd_a_addr,
    input logic [XLEN-1:0]         rd_a_data,
    input logic                    wr_en,
    input logic [AW-1:0]           wr_addr,
    input logic [XLEN-1:0]         wr_data,
    input logic                    wr_fwd,
    input logic [NSHADOW*XLEN-1:0] sh_state,
    input logic [NOPS-1:0]         cx_use,
    input logic [NOPS-1:0]         cx_from_sh,
    input logic [NOPS*SHID_W-1:0]  cx_sh_id,
    input logic [NOPS*XLEN-1:0]    cx_opnd,
    input logic [NOPS-1:0]         cx_move_req,
    input logic                    cx_stall
);
    assert_zero_reg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_addr == '0) |-> (rd_a_data == '0));

    assert_core_writeback_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && ($past(wr_addr) != '0) && ($past(wr_addr) == rd_a_addr))
        |-> (rd_a_data == $past(wr_data)));

    assert_shadow_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_fwd) |=> $stable(sh_state));

    assert_move_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cx_move_req) <= ((NOPS > 2) ? NOPS - 2 : 0));

    assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cx_stall == (cx_move_req != '0));

    for (genvar i = 0; i < NOPS; i++) begin : g_slot
        assert_move_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
            cx_move_req[i] |-> (cx_use[i] && !cx_from_sh[i]));

        assert_unused_slot_R11: assert property (@(posedge clk) disable iff (!rst_n)
            !cx_use[i] |-> ((cx_opnd[i*XLEN +: XLEN] == '0) && !cx_move_req[i]));

        assert_oob_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (cx_use[i] && cx_from_sh[i] && (int'(cx_sh_id[i*SHID_W +: SHID_W]) >= NSHADOW))
            |-> (cx_opnd[i*XLEN +: XLEN] == '0));
    end
endmodule

bind shadow_regfile srf_checker #(
    .XLEN(XLEN), .NSHADOW(NSHADOW), .SHID_W(SHID_W), .NOPS(NOPS), .AW(AW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_a_addr   (rd_a_addr),
    .rd_a_data   (rd_a_data),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .wr_fwd      (wr_fwd),
    .sh_state    (sh_state),
    .cx_use      (cx_use),
    .cx_from_sh  (cx_from_sh),
    .cx_sh_id    (cx_sh_id),
    .cx_opnd     (cx_opnd),
    .cx_move_req (cx_move_req),
    .cx_stall    (cx_stall)
);

// File: tb/shadow_regfile_test.sv
module shadow_regfile_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
    logic        wr_en = 1'b0, wr_fwd = 1'b0;
    logic [1:0]  wr_sub = '0;
    logic [2:0]  wr_shid = '0;
    logic [3:0]  cx_use = '0, cx_from_sh = '0, cx_move_req;
    logic [15:0] cx_core_idx = '0;
    logic [11:0] cx_sh_id = '0;
    logic [127:0] cx_opnd;
    logic        cx_stall;

    int ntests = 0;
    int nfail  = 0;

    shadow_regfile uut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_fwd(wr_fwd), .wr_sub(wr_sub), .wr_shid(wr_shid),
        .cx_use(cx_use), .cx_from_sh(cx_from_sh),
        .cx_core_idx(cx_core_idx), .cx_sh_id(cx_sh_id),
        .cx_opnd(cx_opnd), .cx_move_req(cx_move_req), .cx_stall(cx_stall)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [3:0]  addr;
        logic [31:0] data;
        logic        fwd;
        logic [1:0]  sub;
        logic [2:0]  id;
        logic [31:0] exp_sh;
        logic [31:0] exp_core;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{4'd1, 32'hDEADBEEF, 1'b1, 2'd0, 3'd0, 32'hDEADBEEF, 32'hDEADBEEF},
        '{4'd2, 32'h12345678, 1'b1, 2'd1, 3'd1, 32'h00005678, 32'h12345678},
        '{4'd3, 32'hCAFEF00D, 1'b1, 2'd2, 3'd2, 32'h0000CAFE, 32'hCAFEF00D},
        '{4'd4, 32'h0BADC0DE, 1'b0, 2'd0, 3'd0, 32'hDEADBEEF, 32'h0BADC0DE},
        '{4'd5, 32'hA5A5A5A5, 1'b1, 2'd3, 3'd3, 32'hA5A5A5A5, 32'hA5A5A5A5},
        '{4'd0, 32'h11112222, 1'b1, 2'd1, 3'd1, 32'h00002222, 32'h00000000}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        ntests++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic slot(input int i, input logic u, input logic sh,
                        input logic [3:0] cidx, input logic [2:0] sid);
        cx_use[i]             = u;
        cx_from_sh[i]         = sh;
        cx_core_idx[i*4 +: 4] = cidx;
        cx_sh_id[i*3 +: 3]    = sid;
    endtask

    function automatic logic [31:0] op(input int i);
        return cx_opnd[i*32 +: 32];
    endfunction

    task automatic shadow_read(input logic [2:0] id, input string req, input logic [31:0] exp);
        slot(0, 1'b1, 1'b1, 4'd0, id);
        #1;
        chk(req, op(0), exp);
    endtask

    task automatic set_write(input logic [3:0] a, input logic [31:0] d, input logic f,
                             input logic [1:0] s, input logic [2:0] id);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_fwd = f; wr_sub = s; wr_shid = id;
    endtask

    task automatic clear_write();
        wr_en = 1'b0; wr_fwd = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of both banks
        rd_a_addr = 4'd1; rd_b_addr = 4'd15;
        #1;
        chk("R1 core1", rd_a_data, 32'h0);
        chk("R1 core15", rd_b_data, 32'h0);
        shadow_read(3'd0, "R1 sh0", 32'h0);
        shadow_read(3'd3, "R1 sh3", 32'h0);

        // Table walk: R4 R5 R6 R2
        for (int v = 0; v < 6; v++) begin
            @(negedge clk);
            set_write(VEC[v].addr, VEC[v].data, VEC[v].fwd, VEC[v].sub, VEC[v].id);
            @(negedge clk);
            clear_write();
            rd_a_addr = VEC[v].addr;
            shadow_read(VEC[v].id, "R4/R5/R6 shadow", VEC[v].exp_sh);
            chk("R2/R3 core", rd_a_data, VEC[v].exp_core);
        end

        // R3: no bypass on core read in the write cycle
        @(negedge clk);
        set_write(4'd9, 32'h99990001, 1'b0, 2'd0, 3'd0);
        rd_a_addr = 4'd9;
        #1;
        chk("R3 old value", rd_a_data, 32'h0);
        @(negedge clk);
        clear_write();
        #1;
        chk("R3 new value", rd_a_data, 32'h99990001);

        // R8: shadow write-through in the write cycle; R6 base port has old core
        set_write(4'd6, 32'h55667788, 1'b1, 2'd0, 3'd2);
        rd_b_addr = 4'd6;
        shadow_read(3'd2, "R8 bypass", 32'h55667788);
        chk("R6 base port", rd_b_data, 32'h0);
        @(negedge clk);
        clear_write();
        shadow_read(3'd2, "R8 stored", 32'h55667788);

        // R9: out-of-range shadow id
        set_write(4'd7, 32'h77777777, 1'b1, 2'd0, 3'd5);
        shadow_read(3'd5, "R9 read during write", 32'h0);
        @(negedge clk);
        clear_write();
        shadow_read(3'd5, "R9 read id5", 32'h0);
        shadow_read(3'd4, "R9 read id4", 32'h0);
        shadow_read(3'd0, "R9 sh0 kept", 32'hDEADBEEF);
        shadow_read(3'd1, "R9 sh1 kept", 32'h00002222);
        shadow_read(3'd2, "R9 sh2 kept", 32'h55667788);
        shadow_read(3'd3, "R9 sh3 kept", 32'hA5A5A5A5);

        // R7 R10: core, core, shadow, core
        slot(0, 1'b1, 1'b0, 4'd1, 3'd0);
        slot(1, 1'b1, 1'b0, 4'd2, 3'd0);
        slot(2, 1'b1, 1'b1, 4'd0, 3'd0);
        slot(3, 1'b1, 1'b0, 4'd3, 3'd0);
        #1;
        chk("R7 op0", op(0), 32'hDEADBEEF);
        chk("R7 op1", op(1), 32'h12345678);
        chk("R7 op2", op(2), 32'hDEADBEEF);
        chk("R7 op3", op(3), 32'hCAFEF00D);
        chk("R10 mixed move", {28'h0, cx_move_req}, 32'h8);
        chk("R10 mixed stall", {31'h0, cx_stall}, 32'h1);

        // R10: all core
        slot(2, 1'b1, 1'b0, 4'd4, 3'd0);
        #1;
        chk("R10 all-core move", {28'h0, cx_move_req}, 32'hC);
        chk("R7 op2 core4", op(2), 32'h0BADC0DE);

        // R11: hole in slot 1 (set to shadow source but unused)
        slot(0, 1'b1, 1'b0, 4'd5, 3'd0);
        slot(1, 1'b0, 1'b1, 4'd0, 3'd0);
        slot(2, 1'b1, 1'b0, 4'd9, 3'd0);
        slot(3, 1'b1, 1'b0, 4'd4, 3'd0);
        #1;
        chk("R11 unused op", op(1), 32'h0);
        chk("R10 hole move", {28'h0, cx_move_req}, 32'h8);
        chk("R7 op2 core9", op(2), 32'h99990001);

        // R10: all shadow, no move
        for (int i = 0; i < 4; i++) slot(i, 1'b1, 1'b1, 4'd0, 3'(i));
        #1;
        chk("R10 all-shadow move", {28'h0, cx_move_req}, 32'h0);
        chk("R10 all-shadow stall", {31'h0, cx_stall}, 32'h0);
        chk("R7 sh1", op(1), 32'h00002222);
        chk("R7 sh3", op(3), 32'hA5A5A5A5);

        // R1: reset in mid-run clears both banks
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_a_addr = 4'd1;
        #1;
        chk("R1 core1 after reset", rd_a_data, 32'h0);
        chk("R1 sh0 after reset", op(0), 32'h0);
        chk("R1 sh3 after reset", op(3), 32'h0);

        $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end
endmodule